// File: doc/BRIEF.md
# Processor Supply Supervisor with Pushbutton Reset

This block watches over a processor's supply. It takes three synchronous digital flags: a supply-in-tolerance flag from an external comparator, a secondary sense flag from a second comparator, and an active-low pushbutton. From these it drives a reset on two complementary outputs and an active-low early-warning interrupt. Analog thresholds and references sit outside the block; only their comparator results arrive here.

Reset is active out of power-on. It goes active when the supply leaves tolerance. After the supply recovers, reset is held for a parameterised number of clock cycles, and that hold restarts whenever the supply drops again. The pushbutton is debounced by requiring a run of stable low samples. An accepted press yields a reset pulse of at least the hold length. A press held longer keeps reset active until release, and the hold then counts from the release. The interrupt follows the sense flag and has no link to the reset path.

Top module: `cpu_supervisor`

## Requirements
- R1: While `por_n` is low, `rst_out` is 1, `rst_out_n` is 0 and `warn_n` is 1. After `por_n` rises with the supply flag high and the button released, reset stays active for exactly `RESET_CYCLES` clock edges and is then released.
- R2: `rst_out_n` is always the inverse of `rst_out`.
- R3: A low `supply_ok` sampled at a clock edge makes reset active after that edge. Reset stays active while `supply_ok` stays low.
- R4: Once `supply_ok` is sampled high again, reset is released after exactly `RESET_CYCLES` consecutive high samples and not earlier.
- R5: If `supply_ok` drops during the hold period, the hold count restarts from zero at the next recovery.
- R6: A low level on `pb_n` lasting fewer than `DEBOUNCE_CYCLES` consecutive samples has no effect on reset.
- R7: When `pb_n` is sampled low on `DEBOUNCE_CYCLES` consecutive edges, reset is active after the next edge. After `pb_n` is first sampled high again, reset is released `RESET_CYCLES + 1` edges later.
- R8: A button held low for longer than the hold time keeps reset active for as long as it is held.
- R9: With the default registered interrupt, `warn_n` after each clock edge equals the `sense_ok` value sampled at that edge (0 = sense below trip). The interrupt does not depend on the supply flag, the button or the reset state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| supply_ok | input | 1 | Supply comparator flag, 1 = in tolerance |
| sense_ok | input | 1 | Secondary sense comparator flag, 1 = above trip level |
| pb_n | input | 1 | Pushbutton, active low |
| rst_out | output | 1 | Reset, active high |
| rst_out_n | output | 1 | Reset, active low |
| warn_n | output | 1 | Early-warning interrupt, active low |

## Verification
The hardest case to reach is a supply drop that lands in the middle of a running hold count. From the ports, a restarted count looks just like a count that was never interrupted, unless the exact release edge is measured. The bench recovers the supply, lets part of the hold elapse, drops the flag for one cycle, and then samples one edge before and one edge at the full hold length after the second recovery. A long button hold and a press that misses acceptance by one sample are built the same way, with precise edge counts.

// File: rtl/sup_pkg.sv
package sup_pkg;

   // Width of a counter able to hold values 0..n
   function automatic int cnt_width(input int n);
      int w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

   // Interrupt output timing variant
   typedef enum logic {
      WARN_COMB = 1'b0,
      WARN_FLOP = 1'b1
   } warn_mode_e;

endpackage

// File: rtl/pb_debounce.sv
module pb_debounce #(
   parameter int STABLE_CYCLES = 8
) (
   input  logic clk,
   input  logic por_n,
   input  logic pb_n,
   output logic pressed
);
   import sup_pkg::*;

   localparam int CW = cnt_width(STABLE_CYCLES);

   generate
      if (STABLE_CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) pressed <= 1'b0;
            else        pressed <= ~pb_n;
         end
      end else begin : g_count
         logic [CW-1:0] low_run;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               low_run <= '0;
               pressed <= 1'b0;
            end else if (pb_n) begin
               low_run <= '0;
               pressed <= 1'b0;
            end else if (low_run == CW'(STABLE_CYCLES - 1)) begin
               pressed <= 1'b1;
            end else begin
               low_run <= low_run + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/reset_stretch.sv
module reset_stretch #(
   parameter int HOLD_CYCLES = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic hold,
   output logic active
);
   import sup_pkg::*;

   localparam int CW = cnt_width(HOLD_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

   logic [CW-1:0] elapsed;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         active  <= 1'b1;
         elapsed <= '0;
      end else if (hold) begin
         active  <= 1'b1;
         elapsed <= '0;
      end else if (active) begin
         if (elapsed == LAST) begin
            active  <= 1'b0;
            elapsed <= '0;
         end else begin
            elapsed <= elapsed + 1'b1;
         end
      end
   end
endmodule

// File: rtl/warn_gen.sv
module warn_gen #(
   parameter sup_pkg::warn_mode_e MODE = sup_pkg::WARN_FLOP
) (
   input  logic clk,
   input  logic por_n,
   input  logic sense_ok,
   output logic warn_n
);
   generate
      if (MODE == sup_pkg::WARN_FLOP) begin : g_flop
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) warn_n <= 1'b1;
            else        warn_n <= sense_ok;
         end
      end else begin : g_comb
         assign warn_n = sense_ok;
      end
   endgenerate
endmodule

// File: rtl/cpu_supervisor.sv
module cpu_supervisor #(
   parameter int RESET_CYCLES    = 16,
   parameter int DEBOUNCE_CYCLES = 8,
   parameter sup_pkg::warn_mode_e WARN_MODE = sup_pkg::WARN_FLOP
) (
   input  logic clk,
   input  logic por_n,
   input  logic supply_ok,
   input  logic sense_ok,
   input  logic pb_n,
   output logic rst_out,
   output logic rst_out_n,
   output logic warn_n
);
   if (RESET_CYCLES < 1) begin : g_bad_reset_len
      $error("RESET_CYCLES must be at least 1");
   end
   if (DEBOUNCE_CYCLES < 1) begin : g_bad_debounce_len
      $error("DEBOUNCE_CYCLES must be at least 1");
   end

   logic pb_pressed;
   logic hold_req;
   logic rst_active;

   pb_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_debounce (
      .clk     (clk),
      .por_n   (por_n),
      .pb_n    (pb_n),
      .pressed (pb_pressed)
   );

   assign hold_req = ~supply_ok | pb_pressed;

   reset_stretch #(.HOLD_CYCLES(RESET_CYCLES)) u_stretch (
      .clk    (clk),
      .por_n  (por_n),
      .hold   (hold_req),
      .active (rst_active)
   );

   warn_gen #(.MODE(WARN_MODE)) u_warn (
      .clk      (clk),
      .por_n    (por_n),
      .sense_ok (sense_ok),
      .warn_n   (warn_n)
   );

   assign rst_out   = rst_active;
   assign rst_out_n = ~rst_active;
endmodule

// File: rtl/cpu_supervisor_chk.sv
module cpu_supervisor_chk #(
   parameter int RESET_CYCLES    = 16,
   parameter int DEBOUNCE_CYCLES = 8,
   parameter sup_pkg::warn_mode_e WARN_MODE = sup_pkg::WARN_FLOP
) (
   input logic clk,
   input logic por_n,
   input logic supply_ok,
   input logic sense_ok,
   input logic pb_n,
   input logic rst_out,
   input logic rst_out_n,
   input logic warn_n
);
   import sup_pkg::*;

   localparam int RW = cnt_width(RESET_CYCLES);
   localparam int DW = cnt_width(DEBOUNCE_CYCLES + 1);

   logic [RW-1:0] ok_run;
   logic [DW-1:0] low_run;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ok_run  <= '0;
         low_run <= '0;
      end else begin
         if (!supply_ok)                      ok_run <= '0;
         else if (ok_run != RW'(RESET_CYCLES)) ok_run <= ok_run + 1'b1;
         if (pb_n)                                  low_run <= '0;
         else if (low_run != DW'(DEBOUNCE_CYCLES + 1)) low_run <= low_run + 1'b1;
      end
   end

   a_r2_complement: assert property (@(posedge clk) disable iff (!por_n)
      rst_out_n == ~rst_out);

   a_r3_supply_fail: assert property (@(posedge clk) disable iff (!por_n)
      !supply_ok |=> rst_out);

   a_r4_min_hold: assert property (@(posedge clk) disable iff (!por_n)
      !rst_out |-> ok_run == RW'(RESET_CYCLES));

   a_r7_press_resets: assert property (@(posedge clk) disable iff (!por_n)
      low_run == DW'(DEBOUNCE_CYCLES + 1) |-> rst_out);

   if (WARN_MODE == WARN_FLOP) begin : g_warn_chk
      a_r9_warn_follows: assert property (@(posedge clk) disable iff (!por_n)
         1'b1 |=> warn_n == $past(sense_ok));
   end
endmodule

bind cpu_supervisor cpu_supervisor_chk #(
   .RESET_CYCLES    (RESET_CYCLES),
   .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES),
   .WARN_MODE       (WARN_MODE)
) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .supply_ok (supply_ok),
   .sense_ok  (sense_ok),
   .pb_n      (pb_n),
   .rst_out   (rst_out),
   .rst_out_n (rst_out_n),
   .warn_n    (warn_n)
);

// File: tb/test_cpu_supervisor.sv
module test_cpu_supervisor;
   localparam int RC  = 16;
   localparam int DEB = 8;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic supply_ok = 1'b1;
   logic sense_ok = 1'b1;
   logic pb_n = 1'b1;
   logic rst_out, rst_out_n, warn_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cpu_supervisor #(.RESET_CYCLES(RC), .DEBOUNCE_CYCLES(DEB)) i_cpu_supervisor (
      .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .sense_ok(sense_ok),
      .pb_n(pb_n), .rst_out(rst_out), .rst_out_n(rst_out_n), .warn_n(warn_n)
   );

   typedef struct packed {
      logic       sup;
      logic       sense;
      logic       pb;
      logic [4:0] ticks;
      logic       exp_rst;
      logic       exp_warn_n;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 1'b0, 1'b1, 5'd1,  1'b0, 1'b0, 4'd9},  // R9 sense low
      '{1'b1, 1'b1, 1'b1, 5'd1,  1'b0, 1'b1, 4'd9},  // R9 sense back
      '{1'b0, 1'b1, 1'b1, 5'd1,  1'b1, 1'b1, 4'd3},  // R3 supply fails
      '{1'b0, 1'b0, 1'b1, 5'd3,  1'b1, 1'b0, 4'd3},  // R3 held, R9 low
      '{1'b1, 1'b0, 1'b1, 5'd15, 1'b1, 1'b0, 4'd4},  // R4 one short
      '{1'b1, 1'b1, 1'b1, 5'd1,  1'b0, 1'b1, 4'd4},  // R4 released
      '{1'b1, 1'b1, 1'b1, 5'd4,  1'b0, 1'b1, 4'd9}   // R9 idle
   };

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk_rst(input string tag, input logic exp);
      checks++;
      if (rst_out !== exp) begin
         failures++;
         $display("FAIL %s rst_out actual=%b expected=%b", tag, rst_out, exp);
      end
      checks++;
      if (rst_out_n !== ~exp) begin
         failures++;
         $display("FAIL R2 rst_out_n actual=%b expected=%b", rst_out_n, ~exp);
      end
   endtask

   task automatic chk_warn(input string tag, input logic exp);
      checks++;
      if (warn_n !== exp) begin
         failures++;
         $display("FAIL %s warn_n actual=%b expected=%b", tag, warn_n, exp);
      end
   endtask

   initial begin
      // R1: state under power-on reset
      sense_ok = 1'b0;
      tick(3);
      chk_rst("R1", 1'b1);
      chk_warn("R1", 1'b1);
      sense_ok = 1'b1;
      por_n = 1'b1;
      tick(RC - 1);
      chk_rst("R1", 1'b1);
      tick(1);
      chk_rst("R1", 1'b0);

      // table walk: R3, R4, R9
      for (int v = 0; v < NV; v++) begin
         supply_ok = TBL[v].sup;
         sense_ok  = TBL[v].sense;
         pb_n      = TBL[v].pb;
         tick(int'(TBL[v].ticks));
         chk_rst($sformatf("R%0d", TBL[v].req), TBL[v].exp_rst);
         chk_warn($sformatf("R%0d", TBL[v].req), TBL[v].exp_warn_n);
      end

      // R5: drop during the hold restarts the count
      supply_ok = 1'b0; tick(2);
      supply_ok = 1'b1; tick(5);
      chk_rst("R5", 1'b1);
      supply_ok = 1'b0; tick(1);
      supply_ok = 1'b1; tick(RC - 1);
      chk_rst("R5", 1'b1);
      tick(1);
      chk_rst("R5", 1'b0);

      // R6: short press ignored
      pb_n = 1'b0; tick(DEB - 1);
      pb_n = 1'b1; tick(1);
      chk_rst("R6", 1'b0);
      tick(RC + 2);
      chk_rst("R6", 1'b0);

      // R7: accepted press, minimum-width pulse
      pb_n = 1'b0; tick(DEB);
      chk_rst("R7", 1'b0);
      tick(1);
      chk_rst("R7", 1'b1);
      pb_n = 1'b1; tick(RC);
      chk_rst("R7", 1'b1);
      tick(1);
      chk_rst("R7", 1'b0);

      // R8: long hold keeps reset active
      pb_n = 1'b0; tick(DEB + 1 + 3 * RC);
      chk_rst("R8", 1'b1);
      pb_n = 1'b1; tick(RC);
      chk_rst("R8", 1'b1);
      tick(1);
      chk_rst("R8", 1'b0);

      // R9: interrupt unaffected by supply fail with sense high
      supply_ok = 1'b0; sense_ok = 1'b1; tick(2);
      chk_warn("R9", 1'b1);
      chk_rst("R3", 1'b1);
      supply_ok = 1'b1; tick(RC + 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule